// File: doc/BRIEF.md
# Unaligned Halfword Fetch Aligner

This block sits between a byte-addressable memory that returns one aligned 16-bit word per read and a CPU that asks for 16-bit words or single bytes at any byte address. Two byte-wide holding registers capture the memory's byte lanes. Two output multiplexers, each with a 2-bit select, route either register (or zero) into each half of the result. A word that starts on an odd address spans two aligned memory words. The block builds it from two consecutive reads: the first read captures the requested byte and raises a request for one more read. The control unit then issues a second read two bytes higher, with the second-cycle flag set. That read captures the following byte, and the lanes are crossed on output.

Byte order is big-endian. In an aligned memory word the even address sits on the upper lane and the odd address sits on the lower lane. Each access cycle is marked by a start strobe, and memory data is valid in that same cycle. The assembled result appears through the multiplexers one cycle after the final access cycle, together with a one-cycle completion pulse.

Top module: `ualign_fetch_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, done_o is 0, both selects are 00 and data_o is 0.
- R2: A word access at an even address (addr_lsb_i=0) loads both registers and keeps need_more_o low. One cycle later done_o is 1, sel_hi_o is 10 (upper register), sel_lo_o is 01 (lower register), and data_o equals {byte at A, byte at A+1}.
- R3: The first cycle of a word access at an odd address loads only the lower register, asserts need_more_o, and is followed by a cycle with done_o at 0.
- R4: The second cycle of an odd-address word access (second_i=1 with a first half pending) loads only the upper register and keeps need_more_o low. One cycle later done_o is 1, sel_hi_o is 01, sel_lo_o is 10, and data_o equals {byte at A, byte at A+1}.
- R5: A byte access at an even address loads only the upper register. One cycle later done_o is 1, sel_hi_o is 00, sel_lo_o is 10, and data_o equals {0, byte at A}.
- R6: A byte access at an odd address loads only the lower register. One cycle later done_o is 1, sel_hi_o is 00, sel_lo_o is 01, and data_o equals {0, byte at A}.
- R7: need_more_o is never high during a byte access.
- R8: Neither select output ever carries the code 11.
- R9: In a cycle without start_i there are no loads and no need_more_o. In the cycle after it, done_o is 0 and data_o is unchanged, whatever mem_word_i carries.
- R10: second_i is ignored when no first half is pending. An odd-address word access that arrives with second_i=1 in that state behaves as a first half (R3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | An access cycle is in progress; memory data valid |
| size_word_i | input | 1 | 1 = 16-bit word access, 0 = byte access |
| addr_lsb_i | input | 1 | Bit 0 of the requested byte address |
| second_i | input | 1 | This cycle is the follow-up read of an odd-address word |
| mem_word_i | input | 16 | Aligned word from memory, even address on the upper byte |
| load_hi_o | output | 1 | Load enable of the upper byte register |
| load_lo_o | output | 1 | Load enable of the lower byte register |
| sel_hi_o | output | 2 | Select of the result's upper-half multiplexer |
| sel_lo_o | output | 2 | Select of the result's lower-half multiplexer |
| need_more_o | output | 1 | Request for a second read at the address plus two |
| done_o | output | 1 | One-cycle pulse: data_o holds a complete result |
| data_o | output | 16 | Assembled result |

## Verification
The assertions assume three things about the inputs. mem_word_i is valid in every start_i cycle. Address parity and access size stay the same across both halves of an odd-address word. The follow-up read comes straight after the cycle that raised need_more_o. The stimulus drives each access as one strobe cycle and, when a second read is requested, adds the follow-up strobe in the very next cycle with the word fetched two bytes higher. It places one stray second_i on a fresh access, which the design must ignore. Idle cycles between accesses carry junk on mem_word_i, to show that the held result is immune to it.

// File: rtl/ualign_pkg.sv
package ualign_pkg;

    typedef enum logic [1:0] {
        LANE_ZERO  = 2'b00,
        LANE_LOWER = 2'b01,
        LANE_UPPER = 2'b10
    } lane_sel_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_AWAIT = 1'b1
    } phase_e;

    typedef struct packed {
        logic      ld_hi;
        logic      ld_lo;
        lane_sel_e sel_hi;
        lane_sel_e sel_lo;
        logic      more;
        logic      finish;
    } step_t;

    localparam step_t STEP_NONE = '{ld_hi: 1'b0, ld_lo: 1'b0, sel_hi: LANE_ZERO,
                                    sel_lo: LANE_ZERO, more: 1'b0, finish: 1'b0};

    function automatic step_t plan_step(input logic is_word, input logic odd,
                                        input logic follow_up);
        step_t s;
        s = STEP_NONE;
        if (is_word) begin
            if (!odd) begin
                s.ld_hi  = 1'b1;
                s.ld_lo  = 1'b1;
                s.sel_hi = LANE_UPPER;
                s.sel_lo = LANE_LOWER;
                s.finish = 1'b1;
            end else if (!follow_up) begin
                s.ld_lo  = 1'b1;
                s.more   = 1'b1;
            end else begin
                s.ld_hi  = 1'b1;
                s.sel_hi = LANE_LOWER;
                s.sel_lo = LANE_UPPER;
                s.finish = 1'b1;
            end
        end else begin
            s.finish = 1'b1;
            if (!odd) begin
                s.ld_hi  = 1'b1;
                s.sel_lo = LANE_UPPER;
            end else begin
                s.ld_lo  = 1'b1;
                s.sel_lo = LANE_LOWER;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/ualign_decode.sv
module ualign_decode
    import ualign_pkg::*;
(
    input  logic   start_i,
    input  logic   is_word_i,
    input  logic   odd_i,
    input  logic   follow_up_i,
    output step_t  step_o
);
    always_comb begin
        if (start_i) step_o = plan_step(is_word_i, odd_i, follow_up_i);
        else         step_o = STEP_NONE;
    end
endmodule

// File: rtl/ualign_lane_reg.sv
module ualign_lane_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)       q_o <= '0;
        else if (ld_i) q_o <= d_i;
    end
endmodule

// File: rtl/ualign_lane_mux.sv
module ualign_lane_mux
    import ualign_pkg::*;
#(
    parameter int W = 8
) (
    input  lane_sel_e    sel_i,
    input  logic [W-1:0] upper_i,
    input  logic [W-1:0] lower_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        case (sel_i)
            LANE_UPPER: y_o = upper_i;
            LANE_LOWER: y_o = lower_i;
            default:    y_o = '0;
        endcase
    end
endmodule

// File: rtl/ualign_fetch_ctrl.sv
module ualign_fetch_ctrl
    import ualign_pkg::*;
#(
    parameter  int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              size_word_i,
    input  logic              addr_lsb_i,
    input  logic              second_i,
    input  logic [WORD_W-1:0] mem_word_i,
    output logic              load_hi_o,
    output logic              load_lo_o,
    output logic [1:0]        sel_hi_o,
    output logic [1:0]        sel_lo_o,
    output logic              need_more_o,
    output logic              done_o,
    output logic [WORD_W-1:0] data_o
);
    localparam int LANES = 2;

    phase_e    phase_q;
    step_t     step;
    lane_sel_e sel_q [LANES];
    logic      ld    [LANES];
    logic [BYTE_W-1:0] held [LANES];
    logic [BYTE_W-1:0] muxed [LANES];
    logic      follow_up;

    // The follow-up flag only counts while a first half is outstanding.
    assign follow_up = second_i && (phase_q == PH_AWAIT);

    ualign_decode u_decode (
        .start_i     (start_i),
        .is_word_i   (size_word_i),
        .odd_i       (addr_lsb_i),
        .follow_up_i (follow_up),
        .step_o      (step)
    );

    assign ld[0] = step.ld_lo;
    assign ld[1] = step.ld_hi;

    // Lane 0 = lower byte of the memory word, lane 1 = upper byte.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ualign_lane_reg #(.W(BYTE_W)) u_reg (
            .clk  (clk),
            .rst  (rst),
            .ld_i (ld[g]),
            .d_i  (mem_word_i[g*BYTE_W +: BYTE_W]),
            .q_o  (held[g])
        );
        ualign_lane_mux #(.W(BYTE_W)) u_mux (
            .sel_i   (sel_q[g]),
            .upper_i (held[1]),
            .lower_i (held[0]),
            .y_o     (muxed[g])
        );
        assign data_o[g*BYTE_W +: BYTE_W] = muxed[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            sel_q[0] <= LANE_ZERO;
            sel_q[1] <= LANE_ZERO;
            done_o   <= 1'b0;
        end else begin
            done_o <= step.finish;
            if (start_i) begin
                phase_q  <= step.more ? PH_AWAIT : PH_IDLE;
                sel_q[0] <= step.sel_lo;
                sel_q[1] <= step.sel_hi;
            end
        end
    end

    assign load_hi_o   = step.ld_hi;
    assign load_lo_o   = step.ld_lo;
    assign need_more_o = step.more;
    assign sel_hi_o    = sel_q[1];
    assign sel_lo_o    = sel_q[0];

endmodule

// File: rtl/ualign_checker.sv
module ualign_checker
    import ualign_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              size_word_i,
    input logic              addr_lsb_i,
    input logic              second_i,
    input phase_e            phase_q,
    input logic              load_hi_o,
    input logic              load_lo_o,
    input logic [1:0]        sel_hi_o,
    input logic [1:0]        sel_lo_o,
    input logic              need_more_o,
    input logic              done_o,
    input logic [2*BYTE_W-1:0] data_o
);
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (sel_hi_o != 2'b11) && (sel_lo_o != 2'b11)); // R8

    AST_BYTE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (start_i && !size_word_i) |-> !need_more_o); // R7

    AST_ALIGNED_BOTH: assert property (@(posedge clk) disable iff (rst)
        (start_i && size_word_i && !addr_lsb_i) |-> (load_hi_o && load_lo_o && !need_more_o)); // R2

    AST_ODD_FIRST: assert property (@(posedge clk) disable iff (rst)
        (start_i && size_word_i && addr_lsb_i && phase_q == PH_IDLE)
        |-> (load_lo_o && !load_hi_o && need_more_o)); // R3

    AST_SECOND_CROSS: assert property (@(posedge clk) disable iff (rst)
        (start_i && size_word_i && addr_lsb_i && second_i && phase_q == PH_AWAIT)
        |=> (done_o && sel_hi_o == 2'b01 && sel_lo_o == 2'b10)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !start_i |-> (!load_hi_o && !load_lo_o && !need_more_o)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(data_o) && !done_o)); // R9
endmodule

bind ualign_fetch_ctrl ualign_checker #(.BYTE_W(BYTE_W)) u_checker (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .size_word_i (size_word_i),
    .addr_lsb_i  (addr_lsb_i),
    .second_i    (second_i),
    .phase_q     (phase_q),
    .load_hi_o   (load_hi_o),
    .load_lo_o   (load_lo_o),
    .sel_hi_o    (sel_hi_o),
    .sel_lo_o    (sel_lo_o),
    .need_more_o (need_more_o),
    .done_o      (done_o),
    .data_o      (data_o)
);

// File: tb/ualign_fetch_ctrl_tb_top.sv
module ualign_fetch_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_BYTES  = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        size_word_i = 1'b0;
    logic        addr_lsb_i = 1'b0;
    logic        second_i = 1'b0;
    logic [15:0] mem_word_i = '0;
    logic        load_hi_o, load_lo_o, need_more_o, done_o;
    logic [1:0]  sel_hi_o, sel_lo_o;
    logic [15:0] data_o;

    int checks = 0;
    int failures = 0;
    logic [7:0]  mem [MEM_BYTES];
    logic [15:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ualign_fetch_ctrl dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .size_word_i(size_word_i),
        .addr_lsb_i(addr_lsb_i), .second_i(second_i), .mem_word_i(mem_word_i),
        .load_hi_o(load_hi_o), .load_lo_o(load_lo_o), .sel_hi_o(sel_hi_o),
        .sel_lo_o(sel_lo_o), .need_more_o(need_more_o), .done_o(done_o),
        .data_o(data_o)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_aligned(input int e);
        return {mem[e], mem[e+1]};
    endfunction

    // One access; stray_second drives second_i on the first strobe (R10 stimulus).
    task automatic access(input int a, input bit word, input bit stray_second);
        logic [15:0] held;
        bit odd = a[0];
        int even = a - (a % 2);
        exp_q.push_back(word ? {mem[a], mem[a+1]} : {8'h00, mem[a]});
        @(negedge clk);
        start_i = 1'b1; size_word_i = word; addr_lsb_i = odd;
        second_i = stray_second; mem_word_i = rd_aligned(even);
        #1;
        if (word && !odd) begin
            chk("R2 loads", {load_hi_o, load_lo_o, need_more_o}, 3'b110);
        end else if (word && odd) begin
            chk(stray_second ? "R10 stray second ignored" : "R3 first half",
                {load_hi_o, load_lo_o, need_more_o}, 3'b011);
        end else begin
            chk("R7 byte no more", need_more_o, 1'b0);
            chk(odd ? "R6 byte loads" : "R5 byte loads", {load_hi_o, load_lo_o},
                odd ? 2'b01 : 2'b10);
        end
        if (word && odd) begin
            @(negedge clk);
            second_i = 1'b1; mem_word_i = rd_aligned(even + 2);
            #1;
            chk("R3 no done before second", done_o, 1'b0);
            chk("R4 second loads", {load_hi_o, load_lo_o, need_more_o}, 3'b100);
        end
        @(negedge clk);
        start_i = 1'b0; second_i = 1'b0; mem_word_i = 16'($urandom);
        #1;
        chk("R9 idle no load", {load_hi_o, load_lo_o, need_more_o}, 3'b000);
        chk("R8 sel legal", (sel_hi_o == 2'b11) || (sel_lo_o == 2'b11), 1'b0);
        if (word && !odd)      chk("R2 sels", {sel_hi_o, sel_lo_o}, 4'b1001);
        else if (word && odd)  chk("R4 sels", {sel_hi_o, sel_lo_o}, 4'b0110);
        else if (!odd)         chk("R5 sels", {sel_hi_o, sel_lo_o}, 4'b0010);
        else                   chk("R6 sels", {sel_hi_o, sel_lo_o}, 4'b0001);
        chk(word ? (odd ? "R4 done" : "R2 done") : (odd ? "R6 done" : "R5 done"), done_o, 1'b1);
        if (done_o && exp_q.size() > 0) begin
            logic [15:0] e = exp_q.pop_front();
            chk(word ? (odd ? "R4 data" : "R2 data") : (odd ? "R6 data" : "R5 data"), data_o, e);
        end
        held = data_o;
        @(negedge clk);
        mem_word_i = 16'($urandom);
        #1;
        chk("R9 done drops", done_o, 1'b0);
        chk("R9 data held", data_o, held);
    endtask

    initial begin
        for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'((i * 73 + 29) % 256);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset done", done_o, 1'b0);
        chk("R1 reset sels", {sel_hi_o, sel_lo_o}, 4'b0000);
        chk("R1 reset data", data_o, 16'h0000);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 after reset", {done_o, data_o}, 17'h0);
        access(5, 1'b1, 1'b1);
        for (int a = 0; a < MEM_BYTES - 2; a++) begin
            for (int w = 0; w < 2; w++) access(a, w[0], 1'b0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule